// File: doc/BRIEF.md
# Pulse-Swallow Modulus Controller

This block sits behind an external dual-modulus prescaler. It runs on the prescaler's output as its clock and drives the prescaler's modulus-control line. It also produces one comparison pulse for every complete division period. Each prescaler output cycle lasts either P or P+1 input cycles. In every period the block asks for P+1 during the first A prescaler cycles and for P during the remaining N−A. The input frequency is therefore divided by P·N+A, and the ratio can be set in steps of one input cycle.

The program count N, the swallow count A and a base-modulus select are presented on parallel inputs and captured by a one-clock load strobe. Captured values wait in a staging register. They take over only where one period ends and the next begins, so a period already in progress always completes with the values it started with. The base-modulus select goes out on its own pin, which picks the prescaler's small or large base (8 or 16 on the low band, 64 or 128 on the high band). That pin changes at the same boundary as the counts.

Top module: `swallow_divider`

## Requirements
- R1: While reset is asserted, `mod_hi`, `cmp_pulse` and `big_mod` are all 0, and the staged settings return to N=3, A=0, select=0. The first period after reset therefore lasts 3 clocks with `mod_hi` low throughout.
- R2: Over each period, the sum of P+`mod_hi` taken over its clocks equals P·N+A, where P is the base modulus selected by `big_mod`.
- R3: `cmp_pulse` is high for exactly one clock per period, on the last of the period's N clocks.
- R4: Within a period, `mod_hi` (1 = prescaler divides by P+1) is high on exactly the first A clocks and low afterwards. When A=0 it stays low for the whole period.
- R5: `mod_hi` is low on the clock where `cmp_pulse` is high, provided A<N.
- R6: Values captured by `ld` in the middle of a period leave that period unchanged: its length, its `mod_hi` count and `big_mod` all stay as they were. The new values apply from the next period onward.
- R7: A load whose strobe is sampled at the same edge that ends a period (the edge right after the `cmp_pulse` clock) governs the period that starts at that edge.
- R8: `big_mod` equals the select value of the current period and changes only at a period boundary.
- R9: The extreme settings N=2047 with A=127 and N=3 with A=2, and A=127 with N=128, all meet R2 to R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output, used as the clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld | input | 1 | Load strobe that captures n_in, a_in and band_in |
| n_in | input | NW (11) | Program count N, 3 to 2047 |
| a_in | input | AW (7) | Swallow count A, 0 to 127, smaller than N |
| band_in | input | 1 | Base modulus select; 1 picks the larger base |
| mod_hi | output | 1 | Modulus control; 1 asks the prescaler for P+1 |
| cmp_pulse | output | 1 | One-clock comparison pulse at the end of each period |
| big_mod | output | 1 | Base modulus select of the current period |

## Verification
Two events can land on the same clock edge: the period reload and a load strobe. The bench provokes this by raising `ld` in the clock where `cmp_pulse` is seen. It then requires the period that follows to have the new length and the new `mod_hi` count. In a second case the strobe comes two clocks into a period. There the remainder of that period must still add up to the old N and A, and `big_mod` must stay at the old value until the boundary. A near-exhaustive sweep of all A<N for N from 3 to 12, plus the range extremes, checks the period arithmetic against P·N+A.

// File: rtl/swallow_divider.sv
module swallow_divider #(
  parameter int NW = 11,
  parameter int AW = 7,
  parameter logic [NW-1:0] RST_N = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [NW-1:0] n_in,
  input  logic [AW-1:0] a_in,
  input  logic          band_in,
  output logic          mod_hi,
  output logic          cmp_pulse,
  output logic          big_mod
);
  localparam logic [NW-1:0] NONE = 1;
  localparam logic [AW-1:0] AONE = 1;

  logic [NW-1:0] n_pend, cnt;
  logic [AW-1:0] a_pend, sc;
  logic          sel_pend, sel_q;

  wire [NW-1:0] n_nx   = ld ? n_in : n_pend;
  wire [AW-1:0] a_nx   = ld ? a_in : a_pend;
  wire          sel_nx = ld ? band_in : sel_pend;
  wire          wrap   = (cnt <= NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_pend   <= RST_N;
      a_pend   <= '0;
      sel_pend <= 1'b0;
      cnt      <= '0;
      sc       <= '0;
      sel_q    <= 1'b0;
    end else begin
      n_pend   <= n_nx;
      a_pend   <= a_nx;
      sel_pend <= sel_nx;
      if (wrap) begin
        cnt   <= n_nx;
        sc    <= a_nx;
        sel_q <= sel_nx;
      end else begin
        cnt <= cnt - NONE;
        if (sc != '0) sc <= sc - AONE;
      end
    end
  end

  assign mod_hi    = (sc != '0);
  assign cmp_pulse = (cnt == NONE);
  assign big_mod   = sel_q;
endmodule

// File: rtl/swallow_divider_chk.sv
module swallow_divider_chk #(
  parameter int NW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mod_hi,
  input logic          cmp_pulse,
  input logic          big_mod,
  input logic [NW-1:0] cnt
);
  localparam logic [NW-1:0] NONE = 1;

  a_r3_pulse_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_pulse |=> !cmp_pulse);

  a_r5_mod_low_at_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_pulse |-> !mod_hi);

  a_r4_mod_rises_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_hi) |-> ($past(cmp_pulse) || $past(cnt) == '0));

  a_r6_count_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt > NONE) |=> (cnt == $past(cnt) - NONE));

  a_r8_band_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt > NONE) |=> $stable(big_mod));
endmodule

bind swallow_divider swallow_divider_chk #(.NW(NW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mod_hi(mod_hi), .cmp_pulse(cmp_pulse),
  .big_mod(big_mod), .cnt(cnt)
);

// File: tb/tb_swallow_divider.sv
module tb_swallow_divider;
  logic clk = 0, rst_n = 0, ld = 0, band_in = 0;
  logic [10:0] n_in = '0;
  logic [6:0]  a_in = '0;
  logic mod_hi, cmp_pulse, big_mod;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  swallow_divider dut (
    .clk(clk), .rst_n(rst_n), .ld(ld), .n_in(n_in), .a_in(a_in),
    .band_in(band_in), .mod_hi(mod_hi), .cmp_pulse(cmp_pulse), .big_mod(big_mod)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic sync();
    int k = 0;
    do begin step(); k++; end while (!cmp_pulse && k < 5000);
  endtask

  task automatic period(output int c, output int h, output int bm, output int mp);
    c = 0; h = 0; bm = 0; mp = 0;
    do begin
      step(); c++; h += int'(mod_hi); bm += int'(big_mod);
    end while (!cmp_pulse && c < 5000);
    mp = int'(mod_hi);
  endtask

  task automatic load(int n, int a, int s);
    n_in = 11'(n); a_in = 7'(a); band_in = 1'(s); ld = 1;
    step();
    ld = 0;
  endtask

  task automatic judge(string tag, int n, int a, int s, int c, int h, int bm, int mp);
    int p;
    p = s ? 16 : 8;
    chk({tag, " R3 period clocks"}, c, n);
    chk({tag, " R4 mod_hi clocks"}, h, a);
    chk({tag, " R2 total ratio"}, p * c + h, p * n + a);
    chk({tag, " R5 mod_hi at pulse"}, mp, 0);
    chk({tag, " R8 big_mod"}, bm, s * n);
  endtask

  task automatic cfg(string tag, int n, int a, int s);
    int c, h, bm, mp;
    load(n, a, s);
    sync();
    period(c, h, bm, mp);
    judge(tag, n, a, s, c, h, bm, mp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int c, h, bm, mp;
    repeat (3) @(negedge clk);
    chk("R1 mod_hi in reset", int'(mod_hi), 0);
    chk("R1 pulse in reset", int'(cmp_pulse), 0);
    chk("R1 big_mod in reset", int'(big_mod), 0);
    @(negedge clk); rst_n = 1;
    period(c, h, bm, mp);
    chk("R1 first period clocks", c, 3);
    chk("R1 first period mod_hi", h, 0);

    for (int n = 3; n <= 12; n++)
      for (int a = 0; a < n; a++)
        cfg("sweep", n, a, (n + a) & 1);

    cfg("R9 max", 2047, 127, 1);
    cfg("R9 min", 3, 2, 0);
    cfg("R9 wideA", 128, 127, 0);

    load(10, 4, 0);
    sync();
    period(c, h, bm, mp);
    judge("R6 base", 10, 4, 0, c, h, bm, mp);
    c = 0; h = 0; bm = 0;
    step(); c++; h += int'(mod_hi); bm += int'(big_mod);
    n_in = 11'(5); a_in = 7'(1); band_in = 1; ld = 1;
    step(); c++; h += int'(mod_hi); bm += int'(big_mod);
    ld = 0;
    while (!cmp_pulse && c < 5000) begin
      step(); c++; h += int'(mod_hi); bm += int'(big_mod);
    end
    chk("R6 old period clocks", c, 10);
    chk("R6 old period mod_hi", h, 4);
    chk("R6 old big_mod held", bm, 0);
    period(c, h, bm, mp);
    judge("R6 next", 5, 1, 1, c, h, bm, mp);

    chk("R7 at pulse", int'(cmp_pulse), 1);
    n_in = 11'(7); a_in = 7'(6); band_in = 0; ld = 1;
    period(c, h, bm, mp);
    ld = 0;
    judge("R7 same edge", 7, 6, 0, c, h, bm, mp);
    n_in = 11'(4); a_in = 7'(0); band_in = 1; ld = 1;
    period(c, h, bm, mp);
    ld = 0;
    judge("R7 R4 zero A", 4, 0, 1, c, h, bm, mp);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule